// File: doc/BRIEF.md
# LCD Dot Clock Generator

This block derives the pixel shift clock for a panel interface from a faster core clock. Each dot-clock period lasts a whole number of core cycles: the programmed divisor plus one, or one cycle in bypass. Alongside the divided clock the block gives a one-cycle launch strobe. The strobe serves as a clock enable for the logic that drives the pixel bus, so new data appears half a period before the sampling edge that was chosen.

Every panel configuration has a floor on the period. A TFT panel has no floor beyond one cycle. An STN panel has a floor that depends on colour or monochrome, single or dual scan, and bus width. When the programmed rate is faster than the floor, neither the divisor nor bypass wins: the block runs at the floor and sets an error flag that stays set until reset. In free-running mode the clock never stops. In gated mode it runs only while the data source reports valid pixels. When it stops, it stops low and only after finishing a period.

`data_valid` is a level flag with no ready return. The block never pushes back on the source. The source is expected to hold its data until the launch strobe consumes it.

Top module: `lcd_dotclk_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `dot_clk`, `launch_stb` and `cfg_err` are 0 and the divider is idle.
- R2: With divisor value D, no bypass and no floor above D+1, a period is N=D+1 core cycles. The clock is low for the first N-floor(N/2) cycles of the period and high for the last floor(N/2).
- R3: With a resulting period of 1 (bypass, TFT), `dot_clk` stays 0 and `launch_stb` is 1 in every cycle, so the core clock with the strobe as enable is the dot clock.
- R4: For monochrome STN the period floor is 4 at single/4-bit, 8 at single/8-bit, 8 at dual/8-bit and 16 at dual/16-bit. `if_width` encodes 0=4-bit, 1=8-bit, 2=16-bit. TFT (`panel_stn`=0) has floor 1.
- R5: For colour STN the period floor is 2 at single/4-bit, 2 at single/8-bit, 4 at dual/8-bit and 6 at dual/16-bit.
- R6: If the requested period (1 in bypass, else D+1) is below the floor, the block uses the floor and sets `cfg_err`. `cfg_err` falls only on reset. An STN combination not listed in R4/R5 (`if_width`=3, single/16-bit, dual/4-bit) uses a period of 16 and sets `cfg_err`.
- R7: With `rise_sample`=0, `launch_stb` pulses for one cycle in the cycle `dot_clk` goes high. With `rise_sample`=1, it pulses in the first cycle of each period, when `dot_clk` goes low.
- R8: With `gated_mode`=1, a period starts only at a period boundary (or from idle) where `data_valid` is 1. When it is 0 there, the clock stays low. A started period always runs to its end.
- R9: With `gated_mode`=0, `data_valid` has no effect and the clock runs continuously.
- R10: Changes to the divisor, bypass, panel settings and `rise_sample` take effect only at the start of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Divisor value D, period D+1 |
| bypass | input | 1 | Request a period of one core cycle |
| rise_sample | input | 1 | 1: panel samples on rising edge; 0: on falling edge |
| gated_mode | input | 1 | 1: run only while data is valid |
| panel_stn | input | 1 | 1: STN panel, 0: TFT |
| panel_color | input | 1 | 1: colour STN, 0: monochrome |
| dual_scan | input | 1 | 1: dual scan, 0: single scan |
| if_width | input | 2 | Pixel bus width code (0:4, 1:8, 2:16) |
| data_valid | input | 1 | Pixel data available (gated mode) |
| dot_clk | output | 1 | Divided dot clock |
| launch_stb | output | 1 | One-cycle data launch enable |
| cfg_err | output | 1 | Sticky period-clamp error |

## Verification
The hardest conditions to reach from the ports are a rate change that lands in the middle of a period and a gated stop during the high phase. In both, the old period must finish intact. The bench waits until it sees a rising edge of `dot_clk`. It then changes the divisor, or drops `data_valid`, on the following sample. It measures the distance to the next edge and the length of the high phase against counts worked out by hand. Random configurations, including bypass and reserved width codes, cover the floor table and the sticky error.

// File: rtl/lcd_dotclk_pkg.sv
package lcd_dotclk_pkg;

  typedef enum logic [1:0] {
    IFW_4    = 2'd0,
    IFW_8    = 2'd1,
    IFW_16   = 2'd2,
    IFW_RSVD = 2'd3
  } ifw_e;

  typedef struct packed {
    logic [4:0] per;
    logic       bad;
  } floor_t;

  // Minimum dot period in core cycles for a panel configuration.
  function automatic floor_t period_floor(input logic stn, input logic color,
                                          input logic dual, input ifw_e w);
    floor_t f;
    f.per = 5'd1;
    f.bad = 1'b0;
    if (stn) begin
      unique case ({dual, w})
        {1'b0, IFW_4}:  f.per = color ? 5'd2 : 5'd4;
        {1'b0, IFW_8}:  f.per = color ? 5'd2 : 5'd8;
        {1'b1, IFW_8}:  f.per = color ? 5'd4 : 5'd8;
        {1'b1, IFW_16}: f.per = color ? 5'd6 : 5'd16;
        default: begin
          f.per = 5'd16;
          f.bad = 1'b1;
        end
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/lcd_dotclk_limit.sv
module lcd_dotclk_limit
  import lcd_dotclk_pkg::*;
#(
  parameter int DIV_W = 8,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             bypass,
  input  logic             panel_stn,
  input  logic             panel_color,
  input  logic             dual_scan,
  input  logic [1:0]       if_width,
  output logic [CNT_W-1:0] eff_per,
  output logic             cfg_err
);

  floor_t           flr;
  logic [CNT_W-1:0] req_per;
  logic [CNT_W-1:0] min_per;
  logic             clamp;

  always_comb begin
    flr     = period_floor(panel_stn, panel_color, dual_scan, ifw_e'(if_width));
    req_per = bypass ? CNT_W'(1) : ({1'b0, clk_div} + CNT_W'(1));
    min_per = CNT_W'(flr.per);
    clamp   = flr.bad || (req_per < min_per);
    eff_per = (req_per < min_per) ? min_per : req_per;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_err <= 1'b0;
    else if (clamp) cfg_err <= 1'b1;
  end

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cfg_err));

  assert_err_on_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |=> cfg_err);

endmodule

// File: rtl/lcd_dotclk_div.sv
module lcd_dotclk_div #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] eff_per,
  input  logic             rise_sample,
  input  logic             gated_mode,
  input  logic             data_valid,
  output logic             dot_clk,
  output logic             launch_stb
);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_q;
  logic             edge_q;
  logic [CNT_W-1:0] lo_len;
  logic [CNT_W-1:0] cnt_nx;
  logic             last;
  logic             go;

  always_comb begin
    lo_len = per_q - (per_q >> 1);
    cnt_nx = cnt + CNT_W'(1);
    last   = !active || (cnt == per_q - CNT_W'(1));
    go     = !gated_mode || data_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      cnt        <= '0;
      per_q      <= CNT_W'(1);
      edge_q     <= 1'b0;
      dot_clk    <= 1'b0;
      launch_stb <= 1'b0;
    end else if (last) begin
      cnt     <= '0;
      dot_clk <= 1'b0;
      if (go) begin
        active     <= 1'b1;
        per_q      <= eff_per;
        edge_q     <= rise_sample;
        launch_stb <= rise_sample || (eff_per == CNT_W'(1));
      end else begin
        active     <= 1'b0;
        launch_stb <= 1'b0;
      end
    end else begin
      cnt        <= cnt_nx;
      dot_clk    <= (cnt_nx >= lo_len);
      launch_stb <= !edge_q && (cnt_nx == lo_len);
    end
  end

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!dot_clk && !launch_stb));

  assert_no_runt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dot_clk) |-> ($past(cnt) == $past(per_q) - CNT_W'(1)));

  assert_per_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> $stable(per_q));

  assert_stb_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb && per_q > CNT_W'(1) && !edge_q) |-> (dot_clk && cnt == lo_len));

  assert_stb_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_stb && per_q > CNT_W'(1) && edge_q) |-> (!dot_clk && cnt == '0));

  assert_unit_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && per_q == CNT_W'(1)) |-> !dot_clk);

endmodule

// File: rtl/lcd_dotclk_gen.sv
module lcd_dotclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             bypass,
  input  logic             rise_sample,
  input  logic             gated_mode,
  input  logic             panel_stn,
  input  logic             panel_color,
  input  logic             dual_scan,
  input  logic [1:0]       if_width,
  input  logic             data_valid,
  output logic             dot_clk,
  output logic             launch_stb,
  output logic             cfg_err
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] eff_per;

  lcd_dotclk_limit #(.DIV_W(DIV_W)) u_limit (
    .clk         (clk),
    .rst_n       (rst_n),
    .clk_div     (clk_div),
    .bypass      (bypass),
    .panel_stn   (panel_stn),
    .panel_color (panel_color),
    .dual_scan   (dual_scan),
    .if_width    (if_width),
    .eff_per     (eff_per),
    .cfg_err     (cfg_err)
  );

  lcd_dotclk_div #(.CNT_W(CNT_W)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .eff_per     (eff_per),
    .rise_sample (rise_sample),
    .gated_mode  (gated_mode),
    .data_valid  (data_valid),
    .dot_clk     (dot_clk),
    .launch_stb  (launch_stb)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!dot_clk && !launch_stb && !cfg_err));

endmodule

// File: tb/sim_lcd_dotclk_gen.sv
module sim_lcd_dotclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic       bypass = 1'b0, rise_sample = 1'b0, gated_mode = 1'b0;
  logic       panel_stn = 1'b0, panel_color = 1'b0, dual_scan = 1'b0;
  logic [1:0] if_width = 2'd0;
  logic       data_valid = 1'b0;
  logic       dot_clk, launch_stb, cfg_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  lcd_dotclk_gen #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .bypass(bypass),
    .rise_sample(rise_sample), .gated_mode(gated_mode), .panel_stn(panel_stn),
    .panel_color(panel_color), .dual_scan(dual_scan), .if_width(if_width),
    .data_valid(data_valid), .dot_clk(dot_clk), .launch_stb(launch_stb),
    .cfg_err(cfg_err)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_floor(bit stn, bit col, bit dual, int w, output bit bad);
    bad = 0;
    if (!stn) return 1;
    if (!dual && w == 0) return col ? 2 : 4;
    if (!dual && w == 1) return col ? 2 : 8;
    if (dual && w == 1)  return col ? 4 : 8;
    if (dual && w == 2)  return col ? 6 : 16;
    bad = 1;
    return 16;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!dot_clk && !launch_stb && !cfg_err, "R1", {dot_clk, launch_stb, cfg_err}, 0);
    rst_n = 1'b1;
  endtask

  // Wait for an observed rising edge of dot_clk; returns 0 on timeout.
  task automatic wait_rise(output bit seen);
    bit prev = dot_clk;
    seen = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (dot_clk && !prev) begin seen = 1; break; end
      prev = dot_clk;
    end
  endtask

  // Measure one full period starting at a rise and check shape and strobe.
  task automatic measure(int n, string req);
    bit seen, prev;
    int per = 0, hi = 0, bad_stb = 0;
    if (n == 1) begin
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if (dot_clk || !launch_stb) bad_stb++;
      end
      check(bad_stb == 0, "R3", bad_stb, 0);
      return;
    end
    wait_rise(seen);
    check(seen, req, seen, 1);
    if (!seen) return;
    prev = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      per++;
      if (dot_clk) hi++;
      if (rise_sample) begin
        if (launch_stb != (!dot_clk && prev)) bad_stb++;
      end else begin
        if (launch_stb != (dot_clk && !prev)) bad_stb++;
      end
      if (dot_clk && !prev) break;
      prev = dot_clk;
    end
    check(per == n, {req, " R2 period"}, per, n);
    check(hi == n / 2, "R2 high phase", hi, n / 2);
    check(bad_stb == 0, "R7 strobe", bad_stb, 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit seen, bad, prev;
    int rises, his, stbs, flr, req, n, per;

    // R1 reset state, R2 basic division, TFT
    clk_div = 8'd4;
    do_reset();
    @(negedge clk);
    check(!dot_clk && !cfg_err, "R1", dot_clk, 0);
    measure(5, "R2");

    // R3 bypass on TFT
    bypass = 1'b1;
    do_reset();
    @(negedge clk);
    measure(1, "R3");
    check(!cfg_err, "R3 no error", cfg_err, 0);
    bypass = 1'b0;

    // R4 mono STN dual 16-bit, divisor too fast -> clamp to 16, R6 error
    panel_stn = 1; panel_color = 0; dual_scan = 1; if_width = 2'd2; clk_div = 8'd3;
    do_reset();
    measure(16, "R4");
    check(cfg_err, "R6 clamp", cfg_err, 1);
    // R6 sticky after fixing divisor
    clk_div = 8'd20;
    measure(21, "R6 relaxed");
    check(cfg_err, "R6 sticky", cfg_err, 1);

    // R5 colour STN dual 16-bit bypass -> 6
    panel_color = 1; bypass = 1;
    do_reset();
    measure(6, "R5");
    check(cfg_err, "R5/R6 bypass clamp", cfg_err, 1);
    bypass = 0;

    // R7 rising sample edge, R10 mid-period change
    panel_stn = 0; rise_sample = 1; clk_div = 8'd9;
    do_reset();
    measure(10, "R7");
    wait_rise(seen);
    clk_div = 8'd3;
    per = 0; prev = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      per++;
      if (dot_clk && !prev) break;
      prev = dot_clk;
    end
    check(per == 7, "R10 old period finishes", per, 7);
    measure(4, "R10 new period");
    rise_sample = 0;

    // R8 gated mode: no data -> idle low
    gated_mode = 1; data_valid = 0; clk_div = 8'd5;
    do_reset();
    rises = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dot_clk || launch_stb) rises++;
    end
    check(rises == 0, "R8 idle", rises, 0);
    // single data_valid pulse -> exactly one full period
    data_valid = 1;
    @(negedge clk);
    data_valid = 0;
    rises = 0; his = 0; stbs = 0; prev = dot_clk;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dot_clk && !prev) rises++;
      if (dot_clk) his++;
      if (launch_stb) stbs++;
      prev = dot_clk;
    end
    check(rises == 1, "R8 one period", rises, 1);
    check(his == 3, "R8 no runt", his, 3);
    check(stbs == 1, "R8 one strobe", stbs, 1);
    // data held valid -> continuous
    data_valid = 1;
    measure(6, "R8 continuous");
    // drop valid just after a rise: high phase completes
    wait_rise(seen);
    data_valid = 0;
    his = 1; rises = 0; prev = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dot_clk) his++;
      if (dot_clk && !prev) rises++;
      prev = dot_clk;
    end
    check(his == 3 && rises == 0, "R8 stop at boundary", his, 3);

    // R9 free mode ignores data_valid
    gated_mode = 0; data_valid = 0;
    do_reset();
    measure(6, "R9");
    data_valid = 1;
    measure(6, "R9");
    data_valid = 0;

    // Random configurations
    for (int k = 0; k < 40; k++) begin
      panel_stn   = 1'($urandom % 2);
      panel_color = 1'($urandom % 2);
      dual_scan   = 1'($urandom % 2);
      if_width    = 2'($urandom % 4);
      clk_div     = 8'($urandom % 20);
      bypass      = (($urandom % 6) == 0);
      rise_sample = 1'($urandom % 2);
      flr = exp_floor(panel_stn, panel_color, dual_scan, int'(if_width), bad);
      req = bypass ? 1 : int'(clk_div) + 1;
      n = (req < flr) ? flr : req;
      do_reset();
      measure(n, panel_stn ? (panel_color ? "R5" : "R4") : "R2");
      check(cfg_err == (bad || req < flr), "R6 random", cfg_err, bad || req < flr);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule